// File: doc/BRIEF.md
# UART Interrupt Request Combiner with Address Qualification

This block merges the four status conditions of a UART into a single registered interrupt request. The conditions are transmitter empty, transmission complete, receive data available and receive overrun. Each condition is caught on the rising edge of its status flag and held in a pending bit. The pending bit follows the flag down when the UART clears that flag. An interrupt acknowledge does not clear it.

The pending bits are masked at the output. Each transmit condition has its own enable. The two receive conditions share one enable. The result is then gated by a UART-level enable and a chip-level enable.

An optional address qualifier blocks a data-available event unless the top bit of the received word is 1. A word with that bit set is treated as an address. The position of the top bit depends on the frame-length mode. An address event sets no flag of its own; it appears only as the interrupt request. Parity and address qualification cannot be used together, so the parity enable has no influence on this block.

Top module: `uart_irq_gate`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq` is 0 and no condition is pending.
- R2: A rising edge on an enabled status flag sets its pending bit at the next clock edge. `irq` rises one edge later, so it is high two edges after the flag rises.
- R3: `tx_empty` is masked by `en_tx_empty` alone and `tx_done` by `en_tx_done` alone. Disabling one does not affect the other.
- R4: `en_rx` masks both `rx_avail` and `rx_overrun`.
- R5: With `addr_det_en` = 1, a rise of `rx_avail` becomes pending only if the top bit of `rx_word` is 1 in that cycle.
- R6: The top bit is `rx_word[8]` when `frame9` = 1 and `rx_word[7]` when `frame9` = 0, with the default width of 9. Every other bit is ignored.
- R7: With `addr_det_en` = 0, every rise of `rx_avail` becomes pending, whatever the word.
- R8: `irq` can be 1 only when both `uart_ie` and `global_ie` were 1 at the previous clock edge.
- R9: A pending bit stays set while its flag stays high, whatever the enables. It clears at the first edge that sees the flag low. A source enabled late therefore raises `irq` one edge after it is enabled.
- R10: `parity_en` has no effect on `irq`. An address word is still accepted when `parity_en` = 1.
- R11: A data-available rise that the address qualifier rejects does not become pending later. This holds even if `addr_det_en` is cleared while the flag is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_empty | input | 1 | Transmit buffer empty flag |
| tx_done | input | 1 | Transmission complete flag |
| rx_avail | input | 1 | Receive data available flag |
| rx_overrun | input | 1 | Receive overrun flag |
| rx_word | input | WORD_W (9) | Received word |
| frame9 | input | 1 | 1: 9-bit frames, 0: 8-bit frames |
| en_tx_empty | input | 1 | Enable for the transmit-empty source |
| en_tx_done | input | 1 | Enable for the transmit-complete source |
| en_rx | input | 1 | Shared enable for both receive sources |
| addr_det_en | input | 1 | Address qualification enable |
| parity_en | input | 1 | Parity enable, ignored for qualification |
| uart_ie | input | 1 | UART-level interrupt enable |
| global_ie | input | 1 | Chip-level interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default `WORD_W` of 9, so both top-bit positions (index 8 and index 7) sit inside the word. Directed words such as 0x0FF, 0x100 and 0x080 then separate the two frame modes. They also show that the bit which is not selected is ignored. The four sources all share one generate loop, and each is checked on its own mask path. Random cycles toggle the flags, the enables, `parity_en` and the mode bits against a bench model. This covers enable changes while a flag is held high and qualifier changes in the middle of a flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  typedef enum int {
    SRC_TXE = 0,
    SRC_TXC = 1,
    SRC_RXA = 2,
    SRC_RXO = 3
  } irq_src_e;
endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag,
  input  logic [N-1:0] allow,
  output logic [N-1:0] pend
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        flag_q[i] <= flag[i];
        if (!flag[i])
          pend[i] <= 1'b0;
        else if (!flag_q[i] && allow[i])
          pend[i] <= 1'b1;
      end
    end

    AST_PEND_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
      pend[i] |-> $past(flag[i])); // R9
    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
      !flag[i] |=> !pend[i]); // R9
  end
endmodule

// File: rtl/uart_irq_qual.sv
module uart_irq_qual #(
  parameter int WORD_W = 9
) (
  input  logic [WORD_W-1:0] rx_word,
  input  logic              frame9,
  input  logic              addr_det_en,
  output logic              rxa_allow
);
  localparam int TOP_LONG  = WORD_W - 1;
  localparam int TOP_SHORT = WORD_W - 2;

  logic [WORD_W-1:0] sel_mask;
  logic              top_bit;

  always_comb begin
    sel_mask = '0;
    if (frame9) sel_mask[TOP_LONG]  = 1'b1;
    else        sel_mask[TOP_SHORT] = 1'b1;
    top_bit   = |(rx_word & sel_mask);
    rxa_allow = !addr_det_en || top_bit;
  end
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_empty,
  input  logic              tx_done,
  input  logic              rx_avail,
  input  logic              rx_overrun,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              frame9,
  input  logic              en_tx_empty,
  input  logic              en_tx_done,
  input  logic              en_rx,
  input  logic              addr_det_en,
  input  logic              parity_en,
  input  logic              uart_ie,
  input  logic              global_ie,
  output logic              irq
);
  logic [NUM_SRC-1:0] flags, allow, pend, mask;
  logic               rxa_allow;
  logic               rxa_q;

  uart_irq_qual #(.WORD_W(WORD_W)) u_qual (
    .rx_word     (rx_word),
    .frame9      (frame9),
    .addr_det_en (addr_det_en),
    .rxa_allow   (rxa_allow)
  );

  always_comb begin
    flags          = '0;
    flags[SRC_TXE] = tx_empty;
    flags[SRC_TXC] = tx_done;
    flags[SRC_RXA] = rx_avail;
    flags[SRC_RXO] = rx_overrun;
    allow          = '1;
    allow[SRC_RXA] = rxa_allow;
    mask           = '0;
    mask[SRC_TXE]  = en_tx_empty;
    mask[SRC_TXC]  = en_tx_done;
    mask[SRC_RXA]  = en_rx;
    mask[SRC_RXO]  = en_rx;
  end

  uart_irq_pend #(.N(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .flag  (flags),
    .allow (allow),
    .pend  (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      rxa_q <= 1'b0;
    end else begin
      irq   <= global_ie && uart_ie && |(pend & mask);
      rxa_q <= rx_avail;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(global_ie && uart_ie)); // R8
  AST_ADDR_REJECT: assert property (@(posedge clk) disable iff (rst)
    (addr_det_en && rx_avail && !rxa_q && !rx_word[WORD_W-1] && frame9)
      |=> !pend[SRC_RXA]); // R5
  AST_ADDR_ACCEPT_PARITY: assert property (@(posedge clk) disable iff (rst)
    (addr_det_en && parity_en && rx_avail && !rxa_q && rx_word[WORD_W-1] && frame9)
      |=> pend[SRC_RXA]); // R10
  AST_NO_RAISE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && rxa_q && !pend[SRC_RXA]) |=> !pend[SRC_RXA]); // R11
endmodule

// File: tb/uart_irq_gate_bench.sv
module uart_irq_gate_bench;
  localparam int W = 9;
  logic clk = 1'b0, rst = 1'b1;
  logic tx_empty = 0, tx_done = 0, rx_avail = 0, rx_overrun = 0;
  logic [W-1:0] rx_word = '0;
  logic frame9 = 1, en_tx_empty = 0, en_tx_done = 0, en_rx = 0;
  logic addr_det_en = 0, parity_en = 0, uart_ie = 0, global_ie = 0;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_gate #(.WORD_W(W)) u_uart_irq_gate (.*);

  // reference model built from the requirements
  logic [3:0] m_pend, m_prev;
  logic exp_irq;

  function automatic logic m_allow_rxa(logic ade, logic f9, logic [W-1:0] w);
    return !ade || (f9 ? w[W-1] : w[W-2]);
  endfunction

  function automatic logic m_irq(logic [3:0] p, logic gie, logic uie,
                                 logic ete, logic etd, logic erx);
    return gie && uie && ((p[0] && ete) || (p[1] && etd) || ((p[2] || p[3]) && erx));
  endfunction

  always @(posedge clk) begin
    logic [3:0] f;
    f = {rx_overrun, rx_avail, tx_done, tx_empty};
    if (rst) begin
      m_pend <= '0; m_prev <= '0; exp_irq <= 1'b0;
    end else begin
      exp_irq <= m_irq(m_pend, global_ie, uart_ie, en_tx_empty, en_tx_done, en_rx);
      for (int i = 0; i < 4; i++) begin
        if (!f[i]) m_pend[i] <= 1'b0;
        else if (!m_prev[i] && (i != 2 || m_allow_rxa(addr_det_en, frame9, rx_word)))
          m_pend[i] <= 1'b1;
      end
      m_prev <= f;
    end
  end

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic chk(logic exp, string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%0b expected=%0b at %0t", tag, irq, exp, $time);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: irq=%0b expected=finish", irq);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    chk(1'b0, "R1 during reset");
    rst = 0;
    cyc();
    chk(1'b0, "R1 after reset");

    // R2 latency, R9 clear on flag drop
    global_ie = 1; uart_ie = 1; en_tx_empty = 1;
    tx_empty = 1; cyc(); chk(1'b0, "R2 one edge");
    cyc(); chk(1'b1, "R2 two edges");
    tx_empty = 0; cyc(2); chk(1'b0, "R9 flag dropped");

    // R3 per-source masks, R9 late enable
    en_tx_empty = 0; en_tx_done = 1; tx_empty = 1; cyc(3);
    chk(1'b0, "R3 tx_empty masked");
    en_tx_empty = 1; cyc(); chk(1'b1, "R9 late enable");
    tx_empty = 0; en_tx_empty = 0; tx_done = 1; cyc(2);
    chk(1'b1, "R3 tx_done own enable");
    tx_done = 0; cyc(2);

    // R4 shared receive enable
    en_rx = 0; rx_overrun = 1; cyc(3); chk(1'b0, "R4 overrun masked");
    en_rx = 1; cyc(); chk(1'b1, "R4 overrun enabled");
    rx_overrun = 0; cyc(2);

    // R5 R6 R11 address qualification
    addr_det_en = 1; frame9 = 1; rx_word = 9'h0FF; rx_avail = 1; cyc(3);
    chk(1'b0, "R5 R6 non-address word rejected");
    addr_det_en = 0; cyc(2); chk(1'b0, "R11 no late pending");
    rx_avail = 0; cyc(2);
    addr_det_en = 1; rx_word = 9'h100; rx_avail = 1; cyc(2);
    chk(1'b1, "R5 address word accepted");
    rx_avail = 0; cyc(2);
    frame9 = 0; rx_word = 9'h100; rx_avail = 1; cyc(3);
    chk(1'b0, "R6 8-bit mode uses bit 7");
    rx_avail = 0; cyc(2);
    rx_word = 9'h080; rx_avail = 1; cyc(2);
    chk(1'b1, "R6 8-bit mode bit 7 set");
    rx_avail = 0; cyc(2);

    // R7 qualifier off
    addr_det_en = 0; rx_word = '0; rx_avail = 1; cyc(2);
    chk(1'b1, "R7 any word");
    rx_avail = 0; cyc(2);

    // R10 parity ignored
    addr_det_en = 1; parity_en = 1; frame9 = 1; rx_word = 9'h100; rx_avail = 1; cyc(2);
    chk(1'b1, "R10 parity_en ignored");
    rx_avail = 0; parity_en = 0; addr_det_en = 0; cyc(2);

    // R8 global gating
    en_tx_empty = 1; tx_empty = 1; global_ie = 0; cyc(3);
    chk(1'b0, "R8 global off");
    global_ie = 1; uart_ie = 0; cyc(); chk(1'b0, "R8 uart off");
    uart_ie = 1; cyc(); chk(1'b1, "R8 both on");
    tx_empty = 0; cyc(2);

    // random phase against model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(7) == 0) tx_empty   = ~tx_empty;
      if ($urandom_range(7) == 0) tx_done    = ~tx_done;
      if ($urandom_range(5) == 0) rx_avail   = ~rx_avail;
      if ($urandom_range(9) == 0) rx_overrun = ~rx_overrun;
      rx_word = W'($urandom);
      if ($urandom_range(15) == 0) frame9      = ~frame9;
      if ($urandom_range(11) == 0) addr_det_en = ~addr_det_en;
      if ($urandom_range(11) == 0) parity_en   = ~parity_en;
      if ($urandom_range(9) == 0) en_tx_empty  = ~en_tx_empty;
      if ($urandom_range(9) == 0) en_tx_done   = ~en_tx_done;
      if ($urandom_range(9) == 0) en_rx        = ~en_rx;
      if ($urandom_range(13) == 0) uart_ie     = ~uart_ie;
      if ($urandom_range(13) == 0) global_ie   = ~global_ie;
      cyc();
      chk(exp_irq, "R2 R5 R8 R10 random vs model");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule